// File: doc/BRIEF.md
# FIFO Read Output Stage with Standard and Fall-Through Timing

This block sits at the read side of a single-clock FIFO. It holds the queued words in a small ring store and owns the output word register. It supports two timing modes. The mode is latched while reset is held and stays fixed until the next reset. In standard mode a stored word reaches the output only through an explicit read. The two status outputs then mean "empty" and "full". In fall-through mode the stage moves the oldest stored word to the output by itself. The two status outputs then mean "output ready" and "input ready".

A read select input is sampled on the clock. While it is low, the read enable is ignored inside the block and the output-drive marker goes low, which tells the pad logic to float the bus. A read-port double-rate strap, also sampled in reset, forces standard mode, because fall-through timing is not offered with a double-rate reader.

The control is a three-state machine:
- `ST_STD` is the standard mode. It has no transitions.
- `ST_FT_EMPTY` means no word is presented. It moves to `ST_FT_SHOW` on the edge after the store becomes non-empty (the fill transition).
- `ST_FT_SHOW` means a word is presented. It stays there while reads find more stored words. It returns to `ST_FT_EMPTY` when a read consumes the presented word and the store is empty (the drain transition).

Reset selects `ST_FT_EMPTY` or `ST_STD`.

Top module: `fifo_rd_stage`

## Requirements
- R1: While `rst_n` is low, the stage takes fall-through mode if `fwft_sel_i`=1 and `rd_ddr_i`=0, and standard mode otherwise. Changing `fwft_sel_i` after reset has no effect on the mode.
- R2: With `rd_ddr_i`=1 during reset, the stage is in standard mode whatever `fwft_sel_i` is.
- R3: Standard mode: `rd_flag_o`=1 exactly when no word is stored, and `wr_flag_o`=1 exactly when DEPTH words are stored. A write while full is dropped.
- R4: Standard mode: a read is `rd_en_i`=1 and `rd_sel_i`=1 at a rising edge while the store is not empty. After that edge, `rd_data_o` holds the oldest stored word. No word reaches the output without a read, and a read while empty changes nothing.
- R5: Fall-through mode: a word written into an empty stage at edge k appears on `rd_data_o` with `rd_flag_o`=1 (output ready) after edge k+1, with no read.
- R6: Fall-through mode: each read while `rd_flag_o`=1 replaces the output with the next stored word, in write order. If no word is stored, `rd_flag_o` falls after that edge and `rd_data_o` keeps its value.
- R7: Fall-through mode: `wr_flag_o`=1 (input ready) while fewer than DEPTH words are stored beyond the presented one, so the stage holds DEPTH+1 words. A write while `wr_flag_o`=0 is dropped.
- R8: At an edge where `rd_sel_i`=0, `rd_en_i` is ignored. After every edge, `rd_oe_o` equals the `rd_sel_i` value sampled at that edge (1 = drive, 0 = high impedance).
- R9: `rd_data_o` resets to 0 and keeps its value on every edge at which no word is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read/write clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset; mode straps sampled while low |
| fwft_sel_i | input | 1 | Timing-mode strap: 1 = fall-through |
| rd_ddr_i | input | 1 | Read-port double-rate strap: 1 forces standard mode |
| wr_en_i | input | 1 | Write enable |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read enable |
| rd_sel_i | input | 1 | Synchronous read select, active high |
| rd_data_o | output | WIDTH | Output word register |
| rd_oe_o | output | 1 | Output drive marker, 0 = high impedance |
| rd_flag_o | output | 1 | Empty (standard) / output ready (fall-through) |
| wr_flag_o | output | 1 | Full (standard) / input ready (fall-through) |

## Verification
On every cycle, the embedded properties check the following:
- The store never pops while empty and never exceeds DEPTH words.
- The selected mode never changes between resets.
- The output word stays put on edges with no load.
- A presented fall-through word stays until a read.
- The standard-mode output does not move while the select is low.

The bench scenarios cover the end-to-end behaviour in each strap combination:
- the reset state of the flags;
- the exact fill latency in fall-through mode;
- the flag values at every fill level;
- dropped writes when full;
- blocked reads under a low select;
- the strict data order through a full drain;
- reads past empty.

// File: rtl/frs_pkg.sv
package frs_pkg;

    typedef enum logic [1:0] {
        ST_STD      = 2'd0,
        ST_FT_EMPTY = 2'd1,
        ST_FT_SHOW  = 2'd2
    } frs_state_e;

    function automatic frs_state_e frs_reset_state(input logic ft_mode);
        return ft_mode ? ST_FT_EMPTY : ST_STD;
    endfunction

endpackage

// File: rtl/frs_store.sv
module frs_store #(
    parameter int WIDTH = 10,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] push_data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] head_o,
    output logic             empty_o,
    output logic             full_o
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP  = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr_q, rptr_q;
    logic [CW-1:0]    count_q;
    logic             do_push;

    assign empty_o = (count_q == '0);
    assign full_o  = (count_q == CAP);
    assign head_o  = mem[rptr_q];
    assign do_push = push_i && !full_o;

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wptr_q] <= push_data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
        end else begin
            if (do_push) begin
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            end
            if (pop_i) begin
                rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            end
            unique case ({do_push, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> (count_q != '0)); // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full_o && !pop_i |=> (count_q == CAP)); // R3

endmodule

// File: rtl/frs_ctrl.sv
module frs_ctrl
    import frs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ft_mode_i,
    input  logic rd_req_i,
    input  logic st_empty_i,
    input  logic st_full_i,
    output logic pop_o,
    output logic load_o,
    output logic rd_flag_o,
    output logic wr_flag_o,
    output logic std_mode_o
);
    frs_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= frs_reset_state(ft_mode_i);
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STD: begin
                state_d = ST_STD;
            end
            ST_FT_EMPTY: begin
                if (!st_empty_i) begin
                    state_d = ST_FT_SHOW;
                end
            end
            ST_FT_SHOW: begin
                if (rd_req_i && st_empty_i) begin
                    state_d = ST_FT_EMPTY;
                end
            end
            default: state_d = ST_STD;
        endcase
    end

    always_comb begin
        pop_o      = 1'b0;
        load_o     = 1'b0;
        rd_flag_o  = 1'b0;
        wr_flag_o  = 1'b0;
        std_mode_o = 1'b0;
        unique case (state_q)
            ST_STD: begin
                pop_o      = rd_req_i && !st_empty_i;
                load_o     = rd_req_i && !st_empty_i;
                rd_flag_o  = st_empty_i;
                wr_flag_o  = st_full_i;
                std_mode_o = 1'b1;
            end
            ST_FT_EMPTY: begin
                pop_o     = !st_empty_i;
                load_o    = !st_empty_i;
                rd_flag_o = 1'b0;
                wr_flag_o = !st_full_i;
            end
            ST_FT_SHOW: begin
                pop_o     = rd_req_i && !st_empty_i;
                load_o    = rd_req_i && !st_empty_i;
                rd_flag_o = 1'b1;
                wr_flag_o = !st_full_i;
            end
            default: begin
                std_mode_o = 1'b1;
            end
        endcase
    end

    AST_MODE_STD_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STD) |=> (state_q == ST_STD)); // R1
    AST_MODE_FT_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_STD) |=> (state_q != ST_STD)); // R1
    AST_FT_WORD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FT_SHOW) && !rd_req_i |=> (state_q == ST_FT_SHOW)); // R6
    AST_FT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FT_EMPTY) && !st_empty_i |=> rd_flag_o); // R5

endmodule

// File: rtl/frs_outreg.sv
module frs_outreg #(
    parameter int WIDTH = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] word_i,
    input  logic             sel_i,
    output logic [WIDTH-1:0] data_o,
    output logic             oe_o
);
    logic [WIDTH-1:0] data_q;
    logic             oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= sel_i;
            if (load_i) begin
                data_q <= word_i;
            end
        end
    end

    assign data_o = data_q;
    assign oe_o   = oe_q;

    AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(data_q)); // R9

endmodule

// File: rtl/fifo_rd_stage.sv
module fifo_rd_stage #(
    parameter int WIDTH      = 10,
    parameter int DEPTH      = 8,
    parameter bit FT_SUPPORT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fwft_sel_i,
    input  logic             rd_ddr_i,
    input  logic             wr_en_i,
    input  logic [WIDTH-1:0] wr_data_i,
    input  logic             rd_en_i,
    input  logic             rd_sel_i,
    output logic [WIDTH-1:0] rd_data_o,
    output logic             rd_oe_o,
    output logic             rd_flag_o,
    output logic             wr_flag_o
);
    logic             ft_mode;
    logic             rd_req;
    logic             pop, load;
    logic             st_empty, st_full;
    logic             std_mode;
    logic [WIDTH-1:0] head;

    generate
        if (FT_SUPPORT) begin : g_mode_ft
            assign ft_mode = fwft_sel_i && !rd_ddr_i;
        end else begin : g_mode_std
            assign ft_mode = 1'b0;
        end
    endgenerate

    assign rd_req = rd_en_i && rd_sel_i;

    frs_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (wr_en_i),
        .push_data_i (wr_data_i),
        .pop_i       (pop),
        .head_o      (head),
        .empty_o     (st_empty),
        .full_o      (st_full)
    );

    frs_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ft_mode_i  (ft_mode),
        .rd_req_i   (rd_req),
        .st_empty_i (st_empty),
        .st_full_i  (st_full),
        .pop_o      (pop),
        .load_o     (load),
        .rd_flag_o  (rd_flag_o),
        .wr_flag_o  (wr_flag_o),
        .std_mode_o (std_mode)
    );

    frs_outreg #(
        .WIDTH (WIDTH)
    ) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (load),
        .word_i (head),
        .sel_i  (rd_sel_i),
        .data_o (rd_data_o),
        .oe_o   (rd_oe_o)
    );

    AST_CS_BLOCKS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        std_mode && !rd_sel_i |=> $stable(rd_data_o)); // R8
    AST_STD_EMPTY_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        std_mode && rd_flag_o |=> $stable(rd_data_o)); // R4

endmodule

// File: tb/fifo_rd_stage_test.sv
module fifo_rd_stage_test;
    localparam int W = 10;
    localparam int D = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fwft_sel = 1'b0, rd_ddr = 1'b0;
    logic         wr_en = 1'b0, rd_en = 1'b0, rd_sel = 1'b0;
    logic [W-1:0] wr_data = '0;
    logic [W-1:0] rd_data;
    logic         rd_oe, rd_flag, wr_flag;
    int           checks = 0;
    int           errors = 0;
    bit           done = 1'b0;

    always #2 clk = ~clk;

    fifo_rd_stage #(.WIDTH(W), .DEPTH(D)) uut (
        .clk(clk), .rst_n(rst_n), .fwft_sel_i(fwft_sel), .rd_ddr_i(rd_ddr),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en), .rd_sel_i(rd_sel),
        .rd_data_o(rd_data), .rd_oe_o(rd_oe), .rd_flag_o(rd_flag), .wr_flag_o(wr_flag)
    );

    function automatic int word(int i);
        return (i * 37 + 5) % 1024;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(bit we, int wd, bit re, bit sel);
        wr_en = we; wr_data = W'(wd); rd_en = re; rd_sel = sel;
        @(negedge clk);
    endtask

    task automatic run_cfg(bit fw, bit ddr);
        bit ft;
        int nfill, nrd;
        ft = fw && !ddr;
        rst_n = 1'b0; fwft_sel = fw; rd_ddr = ddr;
        wr_en = 0; rd_en = 0; rd_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fwft_sel = !fw;  // R1: strap change after reset must not matter
        chk("R9 reset data", rd_data, 0);
        chk("R8 reset oe", rd_oe, 0);
        chk(ddr ? "R2 mode flag" : "R1 mode flag", rd_flag, ft ? 0 : 1);
        chk(ft ? "R7 reset in-ready" : "R3 reset full", wr_flag, ft ? 1 : 0);

        cyc(1, word(0), 0, 1);
        chk("R8 oe follows select", rd_oe, 1);
        chk(ft ? "R5 not yet ready" : "R3 not empty", rd_flag, 0);
        chk("R4 no word without read", rd_data, 0);

        cyc(0, 0, 0, 1);
        if (ft) begin
            chk("R5 word fell through", rd_data, word(0));
            chk("R5 output ready", rd_flag, 1);
        end else begin
            chk("R4 still no word", rd_data, 0);
            chk(ddr ? "R2 standard empty flag" : "R3 empty flag", rd_flag, 0);
        end

        nfill = ft ? D : D - 1;
        for (int i = 1; i <= nfill; i++) begin
            cyc(1, word(i), 0, 1);
            if (ft) chk("R7 input ready level", wr_flag, (i < D) ? 1 : 0);
            else    chk("R3 full level", wr_flag, (i + 1 == D) ? 1 : 0);
        end
        cyc(1, 1023, 0, 1);
        chk(ft ? "R7 drop when not ready" : "R3 drop when full", wr_flag, ft ? 0 : 1);

        cyc(0, 0, 1, 0);
        chk("R8 oe low", rd_oe, 0);
        chk("R8 read blocked data", rd_data, ft ? word(0) : 0);
        chk("R8 read blocked flag", wr_flag, ft ? 0 : 1);

        nrd = ft ? D + 1 : D;
        for (int k = 0; k < nrd; k++) begin
            cyc(0, 0, 1, 1);
            if (ft) begin
                chk("R6 next word", rd_data, (k < D) ? word(k + 1) : word(D));
                chk("R6 ready flag", rd_flag, (k < D) ? 1 : 0);
                chk("R7 input ready", wr_flag, 1);
            end else begin
                chk("R4 read order", rd_data, word(k));
                chk("R3 empty flag", rd_flag, (k == D - 1) ? 1 : 0);
                chk("R3 full cleared", wr_flag, 0);
            end
        end

        cyc(0, 0, 1, 1);
        chk(ft ? "R6 hold past empty" : "R4 read empty ignored", rd_data, ft ? word(D) : word(D - 1));
        chk(ft ? "R6 stays not ready" : "R3 stays empty", rd_flag, ft ? 0 : 1);
        cyc(0, 0, 0, 1);
        chk("R9 idle hold", rd_data, ft ? word(D) : word(D - 1));
    endtask

    initial begin
        @(negedge clk);
        run_cfg(1'b0, 1'b0);
        run_cfg(1'b1, 1'b0);
        run_cfg(1'b1, 1'b1);
        run_cfg(1'b0, 1'b1);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule